// File: doc/BRIEF.md
# Interrupt Gate Resolver

This block turns an interrupt or exception vector into a checked handler entry point. A caller presents the vector, whether the event came from a software interrupt instruction or from hardware/processor detection, the current privilege level, and the 48-bit descriptor-table register. The block tests the vector against the table limit. It then fetches the 8-byte gate through a single-beat memory read handshake and classifies the gate as a task, interrupt or trap gate. For interrupt and trap gates it asks a second lookup port for the privilege level of the target code segment.

Once the sequence finishes, the block pulses `done` for one cycle. It reports the handler selector, a 32-bit entry offset, the gate kind, the gate size and a fault code. A limit violation never touches memory. A task gate never touches the segment lookup port. Any fault clears the entry-point fields, so a consumer needs only the fault code to tell whether to branch to the handler.

Top module: `intgate_resolve`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `busy`, `done`, `mem_req` and `cs_req` are 0, and `hnd_sel`, `hnd_off`, `gate_kind`, `gate_wide` and `fault_code` are all zero.
- R2: A `start` pulse is accepted only when `busy` and `done` are both 0. A `start` raised during a lookup changes neither the address being read nor the result.
- R3: The table limit is `idtr[15:0]` and the base is `idtr[47:16]`. When vector*8+7 exceeds the limit, the result is fault 1 (general protection) and `mem_req` is never raised. Exactly equal to the limit passes.
- R4: The gate is read from address base + vector*8. `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen. The 64-bit `mem_rdata` carries the low dword in bits 31:0 and the high dword in bits 63:32.
- R5: The type field is high-dword bits 12:8. 0D110 gives interrupt (`gate_kind`=2), 0D111 gives trap (3), and 00101 gives task (1). Every other value gives fault 1.
- R6: For a software source (`sw_src`=1), a current level numerically greater than the gate DPL (high-dword bits 14:13) gives fault 1. For a hardware source, the gate DPL has no effect.
- R7: A valid gate that passes R6 but has the present bit (high-dword bit 15) clear gives fault 2 (not present). A type or privilege fault takes priority over not-present.
- R8: For interrupt and trap gates, `cs_req` is raised with `cs_sel` equal to the gate selector (low-dword bits 31:16) until `cs_ack`. If `cs_dpl` is greater than the current level, the result is fault 1. The selector's low two bits are never compared.
- R9: A task gate reports its selector, an offset of zero and `gate_wide`=0, and it never raises `cs_req`.
- R10: For a 32-bit gate (D=bit 11 set), the offset is {high[31:16], low[15:0]} and `gate_wide`=1. For a 16-bit gate, the upper 16 offset bits are zero.
- R11: With any nonzero `fault_code`, `hnd_sel`, `hnd_off`, `gate_kind` and `gate_wide` are zero.
- R12: `done` is high for exactly one cycle per accepted request. The result outputs then hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled when idle |
| vector | input | 8 | Interrupt or exception vector |
| sw_src | input | 1 | 1 = software interrupt instruction, 0 = hardware or processor-detected |
| cpl | input | 2 | Current privilege level |
| idtr | input | 48 | Table base in 47:16, limit in 15:0 |
| mem_req | output | 1 | Gate read request |
| mem_addr | output | 32 | Gate byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Gate descriptor |
| cs_req | output | 1 | Code segment privilege lookup request |
| cs_sel | output | 16 | Selector to look up |
| cs_ack | input | 1 | Lookup data valid |
| cs_dpl | input | 2 | Privilege level of the target code segment |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion pulse |
| hnd_sel | output | 16 | Handler selector |
| hnd_off | output | 32 | Handler entry offset |
| gate_kind | output | 2 | 0 none, 1 task, 2 interrupt, 3 trap |
| gate_wide | output | 1 | 1 = 32-bit gate |
| fault_code | output | 2 | 0 none, 1 general protection, 2 not present |

## Verification
The hardest situations to create are those where several checks compete on one gate. Examples are a software request that both violates the gate DPL and points at a not-present gate, and a gate that passes every gate check but targets a less privileged code segment, so the fault appears only after the second handshake. The stimulus table builds each gate field by field, so these combinations are set up directly, and it varies the acknowledge latency of both ports. A directed case raises `start` again in the middle of a memory wait to show that the request in flight is undisturbed.

// File: rtl/intgate_pkg.sv
// Package: shared encodings for the interrupt gate resolver.
// Assumes the fixed 8-byte gate layout; widths here are architectural.
package intgate_pkg;

    localparam int SEL_W  = 16;
    localparam int OFF_W  = 32;
    localparam int PL_W   = 2;
    localparam int DESC_W = 64;

    localparam logic [4:0] TYPE_TASK   = 5'b00101;
    localparam logic [2:0] TAIL_INTR   = 3'b110;
    localparam logic [2:0] TAIL_TRAP   = 3'b111;

    typedef enum logic [1:0] {
        GK_NONE = 2'd0,
        GK_TASK = 2'd1,
        GK_INTR = 2'd2,
        GK_TRAP = 2'd3
    } gate_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_NP   = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_SEG,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [OFF_W-1:0] off;
        gate_kind_e       kind;
        logic             wide;
        fault_e           fault;
    } gate_info_t;

endpackage

// File: rtl/intgate_bounds.sv
// Module: intgate_bounds
// Splits the table register into base and limit, forms the gate address
// and flags a vector whose last descriptor byte lies past the limit.
// Assumes 8-byte gates; purely combinational.
module intgate_bounds #(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16
) (
    input  logic [VEC_W-1:0]        vec,
    input  logic [ADDR_W+LIM_W-1:0] idtr,
    output logic [ADDR_W-1:0]       gate_addr,
    output logic                    over_limit
);
    localparam int SPAN_W = VEC_W + 3;
    localparam int CMP_W  = ((SPAN_W > LIM_W) ? SPAN_W : LIM_W) + 1;

    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [CMP_W-1:0]  last_byte;

    // Separate the register fields and evaluate address and limit test.
    always_comb begin
        base       = idtr[ADDR_W+LIM_W-1:LIM_W];
        limit      = idtr[LIM_W-1:0];
        last_byte  = CMP_W'({vec, 3'b111});
        over_limit = last_byte > CMP_W'(limit);
        gate_addr  = base + ADDR_W'({vec, 3'b000});
    end
endmodule

// File: rtl/intgate_decode.sv
// Module: intgate_decode
// Classifies a fetched gate and applies the gate-level checks:
// type validity, software privilege test, present bit.
// Assumes the high dword arrives without its unused low byte.
module intgate_decode
    import intgate_pkg::*;
(
    input  logic [23:0]      hi_word,
    input  logic [31:0]      lo_word,
    input  logic             sw,
    input  logic [PL_W-1:0]  cur_pl,
    output gate_info_t       info
);
    logic [4:0]      typ;
    logic [PL_W-1:0] gate_dpl;
    logic            present;
    gate_kind_e      kind;

    // Recognise the gate kind from the type field.
    always_comb begin
        typ = hi_word[4:0];
        if (typ == TYPE_TASK)
            kind = GK_TASK;
        else if (!typ[4] && typ[2:0] == TAIL_INTR)
            kind = GK_INTR;
        else if (!typ[4] && typ[2:0] == TAIL_TRAP)
            kind = GK_TRAP;
        else
            kind = GK_NONE;
    end

    // Apply checks in priority order and build the entry point.
    always_comb begin
        gate_dpl = hi_word[6:5];
        present  = hi_word[7];
        info     = '0;
        if (kind == GK_NONE)
            info.fault = FLT_GP;
        else if (sw && (cur_pl > gate_dpl))
            info.fault = FLT_GP;
        else if (!present)
            info.fault = FLT_NP;
        else begin
            info.fault = FLT_NONE;
            info.kind  = kind;
            info.sel   = lo_word[31:16];
            if (kind == GK_TASK) begin
                info.off  = '0;
                info.wide = 1'b0;
            end else begin
                info.wide = typ[3];
                info.off  = typ[3] ? {hi_word[23:8], lo_word[15:0]}
                                   : {16'h0000, lo_word[15:0]};
            end
        end
    end
endmodule

// File: rtl/intgate_seq.sv
// Module: intgate_seq
// Sequencer: accepts a request, runs the gate read, hands the gate to
// the decoder, runs the code segment lookup and holds the result.
// Assumes both handshakes are request-held-until-acknowledge.
module intgate_seq
    import intgate_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               sw_in,
    input  logic [PL_W-1:0]    cpl_in,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               over_in,
    input  logic               mem_ack,
    input  logic [DESC_W-1:0]  mem_rdata,
    input  logic               cs_ack,
    input  logic [PL_W-1:0]    cs_dpl,
    input  gate_info_t         dec_info,
    output logic [DESC_W-1:0]  desc_q,
    output logic               sw_q,
    output logic [PL_W-1:0]    cpl_q,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               cs_req,
    output logic [SEL_W-1:0]   cs_sel,
    output logic               busy,
    output logic               done,
    output gate_info_t         result
);
    seq_state_e        state;
    logic [ADDR_W-1:0] addr_q;

    // Step the lookup and update the held result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            desc_q <= '0;
            sw_q   <= 1'b0;
            cpl_q  <= '0;
            result <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        sw_q   <= sw_in;
                        cpl_q  <= cpl_in;
                        addr_q <= addr_in;
                        result <= '0;
                        if (over_in) begin
                            result.fault <= FLT_GP;
                            state        <= ST_FIN;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        desc_q <= mem_rdata;
                        state  <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    result <= dec_info;
                    if (dec_info.fault != FLT_NONE || dec_info.kind == GK_TASK)
                        state <= ST_FIN;
                    else
                        state <= ST_SEG;
                end
                ST_SEG: begin
                    if (cs_ack) begin
                        if (cs_dpl > cpl_q) begin
                            result       <= '0;
                            result.fault <= FLT_GP;
                        end
                        state <= ST_FIN;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive handshake and status outputs from the state.
    always_comb begin
        mem_req  = (state == ST_FETCH);
        mem_addr = addr_q;
        cs_req   = (state == ST_SEG);
        cs_sel   = result.sel;
        done     = (state == ST_FIN);
        busy     = (state != ST_IDLE) && (state != ST_FIN);
    end
endmodule

// File: rtl/intgate_resolve.sv
// Module: intgate_resolve (top)
// Resolves an interrupt vector to a checked handler entry point using
// a gate read port and a code segment privilege lookup port.
// Assumes a 48-bit table register: base above, limit below.
module intgate_resolve
    import intgate_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 32,
    parameter int LIM_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [VEC_W-1:0]        vector,
    input  logic                    sw_src,
    input  logic [1:0]              cpl,
    input  logic [ADDR_W+LIM_W-1:0] idtr,
    output logic                    mem_req,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_ack,
    input  logic [63:0]             mem_rdata,
    output logic                    cs_req,
    output logic [15:0]             cs_sel,
    input  logic                    cs_ack,
    input  logic [1:0]              cs_dpl,
    output logic                    busy,
    output logic                    done,
    output logic [15:0]             hnd_sel,
    output logic [31:0]             hnd_off,
    output logic [1:0]              gate_kind,
    output logic                    gate_wide,
    output logic [1:0]              fault_code
);
    logic [ADDR_W-1:0] gate_addr;
    logic              over_limit;
    logic [DESC_W-1:0] desc_q;
    logic              sw_q;
    logic [PL_W-1:0]   cpl_q;
    gate_info_t        dec_info;
    gate_info_t        result;

    intgate_bounds #(
        .VEC_W (VEC_W),
        .ADDR_W(ADDR_W),
        .LIM_W (LIM_W)
    ) u_bounds (
        .vec       (vector),
        .idtr      (idtr),
        .gate_addr (gate_addr),
        .over_limit(over_limit)
    );

    intgate_decode u_decode (
        .hi_word(desc_q[63:40]),
        .lo_word(desc_q[31:0]),
        .sw     (sw_q),
        .cur_pl (cpl_q),
        .info   (dec_info)
    );

    intgate_seq #(
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sw_in    (sw_src),
        .cpl_in   (cpl),
        .addr_in  (gate_addr),
        .over_in  (over_limit),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .cs_ack   (cs_ack),
        .cs_dpl   (cs_dpl),
        .dec_info (dec_info),
        .desc_q   (desc_q),
        .sw_q     (sw_q),
        .cpl_q    (cpl_q),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .cs_req   (cs_req),
        .cs_sel   (cs_sel),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    // Present the held result on the output ports.
    always_comb begin
        hnd_sel    = result.sel;
        hnd_off    = result.off;
        gate_kind  = result.kind;
        gate_wide  = result.wide;
        fault_code = result.fault;
    end
endmodule

// File: rtl/intgate_chk.sv
// Module: intgate_chk
// Protocol and result checks for intgate_resolve, attached by bind.
module intgate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_ack,
    input logic        cs_req,
    input logic [15:0] cs_sel,
    input logic        cs_ack,
    input logic        busy,
    input logic        done,
    input logic [15:0] hnd_sel,
    input logic [31:0] hnd_off,
    input logic [1:0]  gate_kind,
    input logic        gate_wide,
    input logic [1:0]  fault_code
);
    // R4
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R8
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_req && !cs_ack) |=> (cs_req && $stable(cs_sel)));

    // R8
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && cs_req));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_req && !cs_req));

    // R11
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault_code != 2'd0) |->
            (hnd_sel == 16'h0 && hnd_off == 32'h0 && gate_kind == 2'd0 && !gate_wide));

    // R9
    task_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && gate_kind == 2'd1) |-> (hnd_off == 32'h0 && !gate_wide));

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!busy && !done) && !busy && !done) |->
            ($stable(hnd_sel) && $stable(hnd_off) && $stable(fault_code)));
endmodule

bind intgate_resolve intgate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .cs_req    (cs_req),
    .cs_sel    (cs_sel),
    .cs_ack    (cs_ack),
    .busy      (busy),
    .done      (done),
    .hnd_sel   (hnd_sel),
    .hnd_off   (hnd_off),
    .gate_kind (gate_kind),
    .gate_wide (gate_wide),
    .fault_code(fault_code)
);

// File: tb/sim_intgate_resolve.sv
module sim_intgate_resolve;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  vector = '0;
    logic        sw_src = 1'b0;
    logic [1:0]  cpl = '0;
    logic [47:0] idtr = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        cs_req;
    logic [15:0] cs_sel;
    logic        cs_ack = 1'b0;
    logic [1:0]  cs_dpl = '0;
    logic        busy;
    logic        done;
    logic [15:0] hnd_sel;
    logic [31:0] hnd_off;
    logic [1:0]  gate_kind;
    logic        gate_wide;
    logic [1:0]  fault_code;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [31:0] BASE = 32'h0010_0000;

    always #5 clk = ~clk;

    intgate_resolve u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vector(vector),
        .sw_src(sw_src), .cpl(cpl), .idtr(idtr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .cs_req(cs_req), .cs_sel(cs_sel),
        .cs_ack(cs_ack), .cs_dpl(cs_dpl), .busy(busy), .done(done),
        .hnd_sel(hnd_sel), .hnd_off(hnd_off), .gate_kind(gate_kind),
        .gate_wide(gate_wide), .fault_code(fault_code)
    );

    typedef struct packed {
        logic [7:0]  vec;
        logic        sw;
        logic [1:0]  pl;
        logic [15:0] lim;
        logic [15:0] sel;
        logic [31:0] off;
        logic        p;
        logic [1:0]  dpl;
        logic [4:0]  typ;
        logic [1:0]  csdpl;
        logic [1:0]  ef;
        logic [1:0]  ek;
        logic        e32;
        logic        ecs;
    } row_t;

    localparam int NROW = 17;
    localparam row_t TBL [NROW] = '{
        '{8'h20,1'b0,2'd3,16'h07FF,16'h0008,32'h1234_5678,1'b1,2'd0,5'b01110,2'd0,2'd0,2'd2,1'b1,1'b1}, // R5 R6 hw ignores DPL
        '{8'h80,1'b1,2'd3,16'h07FF,16'h001B,32'hCAFE_0100,1'b1,2'd3,5'b01111,2'd0,2'd0,2'd3,1'b1,1'b1}, // R8 RPL bits ignored
        '{8'h0E,1'b1,2'd3,16'h07FF,16'h0008,32'h1111_2222,1'b1,2'd0,5'b01110,2'd0,2'd1,2'd0,1'b0,1'b0}, // R6 sw DPL fault
        '{8'h21,1'b1,2'd0,16'h07FF,16'h0010,32'hABCD_4321,1'b1,2'd0,5'b00110,2'd0,2'd0,2'd2,1'b0,1'b1}, // R10 16-bit intr
        '{8'h08,1'b0,2'd0,16'h07FF,16'h0028,32'h5555_AAAA,1'b1,2'd0,5'b00101,2'd0,2'd0,2'd1,1'b0,1'b0}, // R9 task gate
        '{8'h0B,1'b0,2'd0,16'h07FF,16'h0008,32'h0000_1000,1'b0,2'd0,5'b01110,2'd0,2'd2,2'd0,1'b0,1'b0}, // R7 not present
        '{8'h30,1'b0,2'd0,16'h07FF,16'h0008,32'h0000_2000,1'b1,2'd0,5'b01100,2'd0,2'd1,2'd0,1'b0,1'b0}, // R5 bad type
        '{8'h31,1'b0,2'd1,16'h07FF,16'h0008,32'h0000_3000,1'b1,2'd0,5'b01111,2'd2,2'd1,2'd0,1'b0,1'b1}, // R8 cs less privileged
        '{8'h32,1'b0,2'd1,16'h07FF,16'h0009,32'h0000_4000,1'b1,2'd0,5'b01110,2'd1,2'd0,2'd2,1'b1,1'b1}, // R8 cs equal
        '{8'h10,1'b0,2'd0,16'h007F,16'h0008,32'h0000_5000,1'b1,2'd0,5'b01110,2'd0,2'd1,2'd0,1'b0,1'b0}, // R3 past limit
        '{8'h0F,1'b0,2'd0,16'h007F,16'h0008,32'h0000_6000,1'b1,2'd0,5'b01111,2'd0,2'd0,2'd3,1'b1,1'b1}, // R3 exactly at limit
        '{8'h03,1'b1,2'd2,16'h07FF,16'h0008,32'h0000_7000,1'b1,2'd2,5'b01111,2'd0,2'd0,2'd3,1'b1,1'b1}, // R6 equal levels
        '{8'h04,1'b1,2'd3,16'h07FF,16'h0008,32'h0000_8000,1'b0,2'd0,5'b01110,2'd0,2'd1,2'd0,1'b0,1'b0}, // R7 GP over NP
        '{8'h40,1'b0,2'd0,16'h07FF,16'h0008,32'h0000_9000,1'b1,2'd0,5'b10110,2'd0,2'd1,2'd0,1'b0,1'b0}, // R5 bit 12 set
        '{8'h41,1'b0,2'd0,16'h07FF,16'h0030,32'h89AB_0044,1'b1,2'd0,5'b00111,2'd0,2'd0,2'd3,1'b0,1'b1}, // R10 16-bit trap
        '{8'h05,1'b1,2'd3,16'h07FF,16'h0008,32'h0000_A000,1'b1,2'd0,5'b00101,2'd0,2'd1,2'd0,1'b0,1'b0}, // R6 sw task gate
        '{8'hFF,1'b0,2'd0,16'h07FF,16'h0018,32'hDEAD_BEEF,1'b1,2'd0,5'b01110,2'd0,2'd0,2'd2,1'b1,1'b1}  // R3 last vector
    };

    // Record one comparison; print a failure line on mismatch.
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_desc(input row_t r);
        return {r.off[31:16], r.p, r.dpl, r.typ, 8'h00, r.sel, r.off[15:0]};
    endfunction

    bit          mem_seen, cs_seen, addr_moved, got_done;
    logic [31:0] seen_addr;
    logic [15:0] seen_sel;

    // Run one request, answering both ports with a given latency.
    task automatic run_req(input row_t r, input int lat, input bit poke);
        int mw = 0;
        int cw = 0;
        bit poked = 0;
        mem_seen = 0; cs_seen = 0; addr_moved = 0; got_done = 0;
        seen_addr = '0; seen_sel = '0;
        @(negedge clk);
        vector = r.vec; sw_src = r.sw; cpl = r.pl;
        idtr = {BASE, r.lim}; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (c > 0) @(negedge clk);
            start = 1'b0; mem_ack = 1'b0; cs_ack = 1'b0;
            if (done) begin got_done = 1; break; end
            if (mem_req) begin
                if (!mem_seen) seen_addr = mem_addr;
                else if (mem_addr !== seen_addr) addr_moved = 1;
                mem_seen = 1;
                if (poke && !poked) begin
                    poked = 1; start = 1'b1; vector = 8'h01; sw_src = 1'b0;
                end
                if (mw >= lat) begin mem_ack = 1'b1; mem_rdata = mk_desc(r); end
                else mw++;
            end
            if (cs_req) begin
                cs_seen = 1; seen_sel = cs_sel;
                if (cw >= lat) begin cs_ack = 1'b1; cs_dpl = r.csdpl; end
                else cw++;
            end
        end
    endtask

    task automatic check_result(input row_t r, input string tag);
        logic [31:0] eoff;
        logic [15:0] esel;
        bit          ok_lim;
        ok_lim = ({5'b0, r.vec, 3'b111} <= r.lim);
        esel = (r.ef != 0) ? 16'h0 : r.sel;
        eoff = (r.ef != 0 || r.ek == 2'd1) ? 32'h0 : (r.e32 ? r.off : {16'h0, r.off[15:0]});
        chk({tag, " done"}, 64'(got_done), 64'd1);
        chk({tag, " fault"}, 64'(fault_code), 64'(r.ef));
        chk({tag, " kind"}, 64'(gate_kind), 64'(r.ek));
        chk({tag, " wide"}, 64'(gate_wide), 64'(r.e32));
        chk({tag, " sel"}, 64'(hnd_sel), 64'(esel));
        chk({tag, " off"}, 64'(hnd_off), 64'(eoff));
        chk({tag, " R3 read issued"}, 64'(mem_seen), 64'(ok_lim));
        if (ok_lim) begin
            chk({tag, " R4 addr"}, 64'(seen_addr), 64'(BASE + {21'b0, r.vec, 3'b000}));
            chk({tag, " R4 addr stable"}, 64'(addr_moved), 64'd0);
        end
        chk({tag, " R8 seg lookup"}, 64'(cs_seen), 64'(r.ecs));
        if (r.ecs) chk({tag, " R8 seg sel"}, 64'(seen_sel), 64'(r.sel));
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 reqs", 64'({mem_req, cs_req}), 64'd0);
        chk("R1 outputs", 64'({hnd_sel, hnd_off, gate_kind, gate_wide, fault_code}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 64'({busy, done, mem_req, cs_req, fault_code}), 64'd0);

        // Table of gates, with varied acknowledge latency.
        for (int i = 0; i < NROW; i++) begin
            run_req(TBL[i], i % 3, 1'b0);
            check_result(TBL[i], $sformatf("row%0d", i));
        end

        // R2: start raised during the memory wait is ignored.
        run_req(TBL[0], 3, 1'b1);
        check_result(TBL[0], "R2 poke");

        // R12: one-cycle done, then results held while idle.
        run_req(TBL[1], 1, 1'b0);
        @(negedge clk);
        chk("R12 done pulse", 64'(done), 64'd0);
        repeat (4) @(negedge clk);
        chk("R12 hold sel", 64'(hnd_sel), 64'h001B);
        chk("R12 hold off", 64'(hnd_off), 64'hCAFE_0100);
        chk("R12 hold kind", 64'(gate_kind), 64'd3);
        chk("R12 idle", 64'({busy, done}), 64'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule